// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits beside a ring of three-channel counter groups. It decides which signal each channel counts and which signal enables its counting. Every channel has its own pair of stored selections: a 3-bit clock code and a 3-bit gate code. A write port loads both codes for one channel. A combinational read port returns the stored codes for any channel.

The clock can come from several places:
- the channel's own connector pin;
- a clock input shared by its group;
- one of five decade timebases, 10 MHz down to 1 kHz;
- the OUT of the channel before it in the ring.

The gate can be:
- held high;
- held low;
- taken from the channel's own pin;
- taken from the inverted OUT of the channel two places back.

The counters are outside this block. Their OUT signals come in, and the routed clock and gate go out.

The timebases are single-cycle enable pulses. They are derived from a 10 MHz reference tick through a chain of divide-by-ten stages. Any selection that does not use a connector pin turns that pin around to drive the routed signal outward.

Top module: `ccgr_top`

## Requirements
- R1: After reset, every channel holds clock code 0 and gate code 0. Every clock pin output-enable is 0 and every gate pin output-enable is 1. Every routed gate and every driven gate pin is 1.
- R2: A write takes effect when `wr_en_i` is high, `wr_grp_i` < NUM_GROUPS and `wr_ch_i` < 3. It stores `wr_clk_sel_i` and `wr_gate_sel_i` for channel index `wr_grp_i*3+wr_ch_i`. From the next cycle, the read port shows the stored codes for any in-range `rd_grp_i`/`rd_ch_i` in the same cycle. An out-of-range read returns 0.
- R3: A write with `wr_ch_i` = 3 or with `wr_grp_i` >= NUM_GROUPS changes no stored code.
- R4: Clock code 0 routes the channel's `ext_clk_i` bit. Clock code 7 routes the `grp_clk_i` bit of the channel's group.
- R5: Clock codes 1 to 5 route timebase k = code-1. Code 1 is `ref_tick_i` itself. Code k+1 pulses in the cycle of every (10^k)-th reference tick counted from reset.
- R6: Clock code 6 routes `ctr_out_i` of flattened channel i-1 modulo 3*NUM_GROUPS. This means channel 0 of a group takes channel 2 of the preceding group, and group 0 is preceded by the highest group.
- R7: Gate code 0 gives 1, code 1 gives 0, and code 2 routes the channel's `ext_gat_i` bit.
- R8: Gate code 3 routes the inverse of `ctr_out_i` of flattened channel i-2 modulo 3*NUM_GROUPS. Channel 2 takes channel 0 of its own group. Channels 0 and 1 take channel n+1 of the preceding group.
- R9: Gate codes 4 to 7 give a routed gate of 0, and the read port still returns the code as written.
- R10: The clock pin output-enable is 1 exactly when the clock code is not 0. The gate pin output-enable is 1 exactly when the gate code is not 2. A driven pin carries the routed signal, and an undriven pin output is 0. All of these follow a write in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | 10 MHz reference tick, one cycle per period |
| wr_en_i | input | 1 | Selection write strobe |
| wr_grp_i | input | GW | Write group index |
| wr_ch_i | input | 2 | Write channel within group |
| wr_clk_sel_i | input | 3 | Clock code to store |
| wr_gate_sel_i | input | 3 | Gate code to store |
| rd_grp_i | input | GW | Read group index |
| rd_ch_i | input | 2 | Read channel within group |
| rd_clk_sel_o | output | 3 | Stored clock code of the read channel |
| rd_gate_sel_o | output | 3 | Stored gate code of the read channel |
| ext_clk_i | input | NCH | Per-channel clock pin inputs |
| ext_gat_i | input | NCH | Per-channel gate pin inputs |
| grp_clk_i | input | NUM_GROUPS | Group-shared clock inputs |
| ctr_out_i | input | NCH | Counter OUT signals |
| cnt_clk_o | output | NCH | Routed counting clock per channel |
| cnt_gate_o | output | NCH | Routed gate per channel |
| clk_pin_oe_o | output | NCH | Clock pin output-enable |
| clk_pin_o | output | NCH | Clock pin driven value |
| gat_pin_oe_o | output | NCH | Gate pin output-enable |
| gat_pin_o | output | NCH | Gate pin driven value |

## Verification
The pin inputs, the group clocks and the counter OUT signals are toggled independently every cycle. This means a wrong ring neighbour, a missing inversion or a swapped pin shows up as a mismatch rather than agreeing by chance. One phase rewrites random channels with random codes, including out-of-range groups and channel 3, so that write decoding, read-back and reserved gate codes are exercised against one another. A second phase freezes a spread of timebase codes over more than ten thousand reference ticks, with gaps in the tick, so that every divider stage, including the 1 kHz one, is compared at its exact tick count.

// File: rtl/ccgr_pkg.sv
package ccgr_pkg;
  localparam int CH_PER_GRP = 3;
  localparam int NUM_TB     = 5;
  localparam int DEC_DIV    = 10;

  typedef enum logic [2:0] {
    CLK_EXT_PIN  = 3'd0,
    CLK_TB_10M   = 3'd1,
    CLK_TB_1M    = 3'd2,
    CLK_TB_100K  = 3'd3,
    CLK_TB_10K   = 3'd4,
    CLK_TB_1K    = 3'd5,
    CLK_PREV_OUT = 3'd6,
    CLK_GRP_EXT  = 3'd7
  } clk_sel_e;

  typedef enum logic [2:0] {
    GT_HIGH    = 3'd0,
    GT_LOW     = 3'd1,
    GT_PIN     = 3'd2,
    GT_INV_OUT = 3'd3
  } gate_sel_e;

  typedef struct packed {
    logic [2:0] clk_sel;
    logic [2:0] gate_sel;
  } chan_sel_t;
endpackage

// File: rtl/ccgr_decade_div.sv
module ccgr_decade_div #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (in_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign out_o = in_i && (cnt_q == LAST);

  AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o |=> !out_o); // R5
endmodule

// File: rtl/ccgr_timebase.sv
module ccgr_timebase
  import ccgr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  output logic [NUM_TB-1:0] tb_o
);
  assign tb_o[0] = ref_tick_i;

  for (genvar k = 1; k < NUM_TB; k++) begin : g_stage
    ccgr_decade_div #(.DIV(DEC_DIV)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (tb_o[k-1]),
      .out_o (tb_o[k])
    );

    AST_TB_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tb_o[k] |-> tb_o[k-1]); // R5
  end
endmodule

// File: rtl/ccgr_sel_bank.sv
module ccgr_sel_bank
  import ccgr_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GW         = 2,
  parameter int NCH        = NUM_GROUPS * CH_PER_GRP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [GW-1:0]   wr_grp_i,
  input  logic [1:0]      wr_ch_i,
  input  chan_sel_t       wr_sel_i,
  input  logic [GW-1:0]   rd_grp_i,
  input  logic [1:0]      rd_ch_i,
  output chan_sel_t       rd_sel_o,
  output chan_sel_t [NCH-1:0] sel_o
);
  chan_sel_t [NCH-1:0] sel_q;
  logic wr_hit, rd_hit;
  int   wr_idx, rd_idx;

  always_comb begin
    wr_hit = wr_en_i && (int'(wr_grp_i) < NUM_GROUPS) && (int'(wr_ch_i) < CH_PER_GRP);
    wr_idx = int'(wr_grp_i) * CH_PER_GRP + int'(wr_ch_i);
    rd_hit = (int'(rd_grp_i) < NUM_GROUPS) && (int'(rd_ch_i) < CH_PER_GRP);
    rd_idx = int'(rd_grp_i) * CH_PER_GRP + int'(rd_ch_i);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     sel_q[i] <= '0;
      else if (wr_hit && wr_idx == i)  sel_q[i] <= wr_sel_i;
    end

    AST_WR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit && wr_idx == i) |=> (sel_o[i] == $past(wr_sel_i))); // R2
  end

  always_comb begin
    rd_sel_o = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_hit && rd_idx == i) rd_sel_o = sel_q[i];
  end

  assign sel_o = sel_q;

  AST_WR_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_ch_i) >= CH_PER_GRP)) |=> $stable(sel_o)); // R3
endmodule

// File: rtl/ccgr_chan_mux.sv
module ccgr_chan_mux
  import ccgr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chan_sel_t         sel_i,
  input  logic [NUM_TB-1:0] tb_i,
  input  logic              ext_clk_i,
  input  logic              grp_clk_i,
  input  logic              prev_out_i,
  input  logic              ext_gat_i,
  input  logic              back2_out_i,
  output logic              clk_o,
  output logic              gate_o,
  output logic              clk_oe_o,
  output logic              clk_pin_o,
  output logic              gat_oe_o,
  output logic              gat_pin_o
);
  always_comb begin
    unique case (clk_sel_e'(sel_i.clk_sel))
      CLK_EXT_PIN:  clk_o = ext_clk_i;
      CLK_TB_10M:   clk_o = tb_i[0];
      CLK_TB_1M:    clk_o = tb_i[1];
      CLK_TB_100K:  clk_o = tb_i[2];
      CLK_TB_10K:   clk_o = tb_i[3];
      CLK_TB_1K:    clk_o = tb_i[4];
      CLK_PREV_OUT: clk_o = prev_out_i;
      CLK_GRP_EXT:  clk_o = grp_clk_i;
      default:      clk_o = 1'b0;
    endcase
  end

  always_comb begin
    case (gate_sel_e'(sel_i.gate_sel))
      GT_HIGH:    gate_o = 1'b1;
      GT_LOW:     gate_o = 1'b0;
      GT_PIN:     gate_o = ext_gat_i;
      GT_INV_OUT: gate_o = !back2_out_i;
      default:    gate_o = 1'b0; // reserved codes disable
    endcase
  end

  assign clk_oe_o  = (sel_i.clk_sel != CLK_EXT_PIN);
  assign gat_oe_o  = (sel_i.gate_sel != GT_PIN);
  assign clk_pin_o = clk_oe_o && clk_o;
  assign gat_pin_o = gat_oe_o && gate_o;

  AST_CLK_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe_o |-> (clk_o == ext_clk_i)); // R4
  AST_GATE_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.gate_sel[2] |-> !gate_o); // R9
  AST_PIN_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe_o |-> !clk_pin_o); // R10
  AST_GAT_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gat_oe_o |-> (gat_pin_o == gate_o)); // R10
endmodule

// File: rtl/ccgr_top.sv
module ccgr_top
  import ccgr_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter int NCH        = NUM_GROUPS * CH_PER_GRP
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_tick_i,
  input  logic                  wr_en_i,
  input  logic [GW-1:0]         wr_grp_i,
  input  logic [1:0]            wr_ch_i,
  input  logic [2:0]            wr_clk_sel_i,
  input  logic [2:0]            wr_gate_sel_i,
  input  logic [GW-1:0]         rd_grp_i,
  input  logic [1:0]            rd_ch_i,
  output logic [2:0]            rd_clk_sel_o,
  output logic [2:0]            rd_gate_sel_o,
  input  logic [NCH-1:0]        ext_clk_i,
  input  logic [NCH-1:0]        ext_gat_i,
  input  logic [NUM_GROUPS-1:0] grp_clk_i,
  input  logic [NCH-1:0]        ctr_out_i,
  output logic [NCH-1:0]        cnt_clk_o,
  output logic [NCH-1:0]        cnt_gate_o,
  output logic [NCH-1:0]        clk_pin_oe_o,
  output logic [NCH-1:0]        clk_pin_o,
  output logic [NCH-1:0]        gat_pin_oe_o,
  output logic [NCH-1:0]        gat_pin_o
);
  logic [NUM_TB-1:0]   tb;
  chan_sel_t [NCH-1:0] sel;
  chan_sel_t           wr_sel, rd_sel;

  assign wr_sel.clk_sel  = wr_clk_sel_i;
  assign wr_sel.gate_sel = wr_gate_sel_i;
  assign rd_clk_sel_o    = rd_sel.clk_sel;
  assign rd_gate_sel_o   = rd_sel.gate_sel;

  ccgr_timebase u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_tick_i(ref_tick_i),
    .tb_o      (tb)
  );

  ccgr_sel_bank #(.NUM_GROUPS(NUM_GROUPS), .GW(GW), .NCH(NCH)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_grp_i(wr_grp_i),
    .wr_ch_i (wr_ch_i),
    .wr_sel_i(wr_sel),
    .rd_grp_i(rd_grp_i),
    .rd_ch_i (rd_ch_i),
    .rd_sel_o(rd_sel),
    .sel_o   (sel)
  );

  // ring over flattened channels: i-1 for clock chain, i-2 for inverted gate
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int PREV  = (i + NCH - 1) % NCH;
    localparam int BACK2 = (i + NCH - 2) % NCH;
    localparam int GRP   = i / CH_PER_GRP;

    ccgr_chan_mux u_mux (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel[i]),
      .tb_i       (tb),
      .ext_clk_i  (ext_clk_i[i]),
      .grp_clk_i  (grp_clk_i[GRP]),
      .prev_out_i (ctr_out_i[PREV]),
      .ext_gat_i  (ext_gat_i[i]),
      .back2_out_i(ctr_out_i[BACK2]),
      .clk_o      (cnt_clk_o[i]),
      .gate_o     (cnt_gate_o[i]),
      .clk_oe_o   (clk_pin_oe_o[i]),
      .clk_pin_o  (clk_pin_o[i]),
      .gat_oe_o   (gat_pin_oe_o[i]),
      .gat_pin_o  (gat_pin_o[i])
    );

    AST_RING_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_grp_i == GW'(GRP) && rd_ch_i == 2'(i % CH_PER_GRP) && rd_clk_sel_o == 3'd6)
        |-> (cnt_clk_o[i] == ctr_out_i[PREV])); // R6
    AST_RING_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_grp_i == GW'(GRP) && rd_ch_i == 2'(i % CH_PER_GRP) && rd_gate_sel_o == 3'd3)
        |-> (cnt_gate_o[i] != ctr_out_i[BACK2])); // R8
  end
endmodule

// File: tb/ccgr_top_tb.sv
module ccgr_top_tb;
  localparam int NG  = 3;
  localparam int GW  = 2;
  localparam int NCH = NG * 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_tick = 1'b0, wr_en = 1'b0;
  logic [GW-1:0] wr_grp = '0, rd_grp = '0;
  logic [1:0] wr_ch = '0, rd_ch = '0;
  logic [2:0] wr_clk = '0, wr_gate = '0;
  logic [2:0] rd_clk, rd_gate;
  logic [NCH-1:0] ext_clk = '0, ext_gat = '0, ctr_out = '0;
  logic [NG-1:0]  grp_clk = '0;
  logic [NCH-1:0] cnt_clk, cnt_gate, clk_oe, clk_pin, gat_oe, gat_pin;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit chk_on = 0;

  int mclk[NCH];
  int mgate[NCH];
  longint ntick;

  always #10 clk = ~clk;

  ccgr_top #(.NUM_GROUPS(NG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .wr_grp_i(wr_grp), .wr_ch_i(wr_ch),
    .wr_clk_sel_i(wr_clk), .wr_gate_sel_i(wr_gate),
    .rd_grp_i(rd_grp), .rd_ch_i(rd_ch),
    .rd_clk_sel_o(rd_clk), .rd_gate_sel_o(rd_gate),
    .ext_clk_i(ext_clk), .ext_gat_i(ext_gat), .grp_clk_i(grp_clk),
    .ctr_out_i(ctr_out),
    .cnt_clk_o(cnt_clk), .cnt_gate_o(cnt_gate),
    .clk_pin_oe_o(clk_oe), .clk_pin_o(clk_pin),
    .gat_pin_oe_o(gat_oe), .gat_pin_o(gat_pin)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic longint pow10(int k);
    longint p = 1;
    for (int j = 0; j < k; j++) p = p * 10;
    return p;
  endfunction

  // reference model state
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin mclk[i] = 0; mgate[i] = 0; end
      ntick = 0;
    end else begin
      if (wr_en && wr_grp < NG && wr_ch < 3) begin
        mclk[wr_grp*3 + wr_ch]  = wr_clk;
        mgate[wr_grp*3 + wr_ch] = wr_gate;
      end
      if (ref_tick) ntick = ntick + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [NCH-1:0] e_clk, e_gate, e_coe, e_cpin, e_goe, e_gpin;
      int rc, rg;
      for (int i = 0; i < NCH; i++) begin
        case (mclk[i])
          0: e_clk[i] = ext_clk[i];
          6: e_clk[i] = ctr_out[(i + NCH - 1) % NCH];
          7: e_clk[i] = grp_clk[i / 3];
          default: e_clk[i] = ref_tick && (((ntick + 1) % pow10(mclk[i] - 1)) == 0);
        endcase
        case (mgate[i])
          0: e_gate[i] = 1'b1;
          2: e_gate[i] = ext_gat[i];
          3: e_gate[i] = !ctr_out[(i + NCH - 2) % NCH];
          default: e_gate[i] = 1'b0;
        endcase
        e_coe[i]  = (mclk[i] != 0);
        e_goe[i]  = (mgate[i] != 2);
        e_cpin[i] = e_coe[i] && e_clk[i];
        e_gpin[i] = e_goe[i] && e_gate[i];
      end
      rc = 0; rg = 0;
      if (rd_grp < NG && rd_ch < 3) begin
        rc = mclk[rd_grp*3 + rd_ch];
        rg = mgate[rd_grp*3 + rd_ch];
      end
      check("R2 R3 R9", "rd_clk_sel", 32'(rd_clk), 32'(rc));
      check("R2 R3 R9", "rd_gate_sel", 32'(rd_gate), 32'(rg));
      check("R4 R5 R6", "cnt_clk", 32'(cnt_clk), 32'(e_clk));
      check("R7 R8 R9", "cnt_gate", 32'(cnt_gate), 32'(e_gate));
      check("R10", "clk_pin_oe", 32'(clk_oe), 32'(e_coe));
      check("R10", "clk_pin", 32'(clk_pin), 32'(e_cpin));
      check("R10", "gat_pin_oe", 32'(gat_oe), 32'(e_goe));
      check("R10", "gat_pin", 32'(gat_pin), 32'(e_gpin));
    end
  end

  task automatic rand_inputs(bit allow_wr);
    ext_clk  = NCH'($urandom);
    ext_gat  = NCH'($urandom);
    ctr_out  = NCH'($urandom);
    grp_clk  = NG'($urandom);
    ref_tick = ($urandom_range(9) != 0);
    rd_grp   = GW'($urandom);
    rd_ch    = 2'($urandom);
    wr_en    = allow_wr && ($urandom_range(7) == 0);
    wr_grp   = GW'($urandom);
    wr_ch    = 2'($urandom);
    wr_clk   = 3'($urandom);
    wr_gate  = 3'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ext_clk = '1; ctr_out = '1;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", "clk_pin_oe", 32'(clk_oe), 32'(0));
    check("R1", "gat_pin_oe", 32'(gat_oe), 32'({NCH{1'b1}}));
    check("R1", "cnt_gate", 32'(cnt_gate), 32'({NCH{1'b1}}));
    check("R1", "gat_pin", 32'(gat_pin), 32'({NCH{1'b1}}));
    check("R1", "cnt_clk", 32'(cnt_clk), 32'(ext_clk));
    chk_on = 1;
    // phase A: random writes, including out-of-range group and channel 3
    for (int c = 0; c < 8000; c++) begin
      @(posedge clk); #1;
      rand_inputs(1'b1);
    end
    // phase B: freeze timebase codes over >10^4 ticks (R5)
    for (int i = 0; i < NCH; i++) begin
      @(posedge clk); #1;
      rand_inputs(1'b0);
      wr_en = 1'b1; wr_grp = GW'(i / 3); wr_ch = 2'(i % 3);
      wr_clk = 3'(1 + (i % 5)); wr_gate = 3'(i % 8);
    end
    for (int c = 0; c < 13000; c++) begin
      @(posedge clk); #1;
      rand_inputs(1'b0);
    end
    @(posedge clk); #1;
    chk_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule